// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small accumulator processor whose sequencing comes from a control-store ROM rather than hard-wired state logic. A micro-program counter addresses the ROM and the selected word is latched into a micro-instruction register each cycle. Every micro-step performs exactly one register transfer, memory access or sequencing action on a datapath made of an accumulator, a program counter, a memory address register, a memory data register, a scratch register and an instruction register.

Programs live in an external word-addressed memory of 512 words of 32 bits, reached through a synchronous port: a write is taken on the clock edge, and read data for the address presented in one cycle is returned after the next edge. Each instruction word carries its opcode in bits 31:16 and its operand in bits 15:0. The core fetches a word, dispatches on the opcode to a fixed micro-routine and returns to fetch when the routine finishes. HALT and illegal opcodes stop the core until reset. A debug view exposes the accumulator, program counter, instruction register and micro-program counter.

Top module: `cpu_uc_core`

## Requirements
- R1: While reset is asserted and directly after its release, the program counter, the accumulator and the micro-program counter read 0, `halted` and `error` are 0 and `mem_we` is 0.
- R2: Fetch occupies micro-steps 0 to 4, in order: address from the program counter, memory read, instruction register load, operand to the data register, dispatch. Dispatch jumps to micro-address 10 times the opcode in bits 31:16, with opcodes 1 add, 2 subtract, 3 load, 4 store, 5 branch, 6 branch-if-zero, 7 load-immediate, 8 halt. Fetch never writes memory.
- R3: Load-immediate (opcode 7) places the sign-extended operand in the accumulator and advances the program counter by one, the increment passing through the accumulator.
- R4: Add (1) and subtract (2) combine the accumulator with the memory word at the low 9 bits of the operand, in 32-bit two's complement with wraparound.
- R5: Load (3) copies the memory word at the low 9 bits of the operand into the accumulator; store (4) writes the accumulator to that word. Operand bits above bit 8 are ignored for addressing.
- R6: Branch (5) sets the program counter to the operand.
- R7: Branch-if-zero (6) runs a skip that advances the micro-program counter from 60 to 62 when the accumulator is zero, loading the program counter from the operand; otherwise it goes to 61 and the program counter advances by one with the accumulator unchanged.
- R8: Halt (opcode 8, micro-address 80) sets `halted`, which stays set until reset; afterwards the program counter and accumulator are frozen and no memory write occurs.
- R9: Any opcode outside 1 to 8 sets both `error` and `halted`, leaving the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 9 | Word address for memory access |
| mem_we | output | 1 | Write strobe for the current cycle |
| mem_wdata | output | 32 | Data to write |
| mem_rdata | input | 32 | Registered read data, one cycle after the address |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Stop was caused by an illegal opcode |
| dbg_acc | output | 32 | Accumulator |
| dbg_pc | output | 16 | Program counter |
| dbg_ir | output | 32 | Instruction register |
| dbg_upc | output | 7 | Micro-program counter |

## Verification
The arrival of read data and its first use fall in the same cycle: the step right after a read both captures the returning word into the data register and consumes it (instruction register load in fetch, the scratch load in add and subtract, the accumulator load in load). Every program provokes this in fetch, and the arithmetic and load tests judge it by the final accumulator and stored words, which only come out right if the consumer saw the fresh word rather than the stale register. The micro-address trace of a load-immediate and the skip outcome of the conditional branch check the sequencing around it.

// File: rtl/cpu_uc_pkg.sv
package cpu_uc_pkg;

   localparam int UPC_W      = 7;
   localparam int ENT_STRIDE = 10;
   localparam int NUM_OPC    = 8;
   localparam int HALT_ENTRY = 80;
   localparam int ILL_ENTRY  = 85;

   typedef enum logic [4:0] {
      U_NOP, U_SAR_PC, U_READ, U_IR_SDR, U_SDR_OPND, U_DISPATCH,
      U_TMP_ACC, U_ACC_PCINC, U_PC_ACC, U_ACC_TMP, U_TMP_SDR, U_SAR_TMP,
      U_ADD, U_SUB, U_ACC_SDR, U_ACC_IMM, U_SDR_ACC, U_WRITE,
      U_PC_SDR, U_SKIP, U_JUMP, U_HALT, U_ILLEGAL
   } uop_e;

   typedef struct packed {
      uop_e             op;
      logic [UPC_W-1:0] tgt;
   } uword_t;

   // shared prologue of the memory-operand routines: bump PC via ACC, operand to SAR
   function automatic uop_e prologue_op(input int off);
      case (off)
         0:       prologue_op = U_TMP_ACC;
         1:       prologue_op = U_ACC_PCINC;
         2:       prologue_op = U_PC_ACC;
         3:       prologue_op = U_ACC_TMP;
         4:       prologue_op = U_TMP_SDR;
         default: prologue_op = U_SAR_TMP;
      endcase
   endfunction

   function automatic uword_t urom(input logic [UPC_W-1:0] a);
      int blk, off;
      uword_t w;
      blk = int'(a) / ENT_STRIDE;
      off = int'(a) % ENT_STRIDE;
      w   = '{op: U_NOP, tgt: '0};
      if (blk >= 1 && blk <= 4 && off <= 5) begin
         w.op = prologue_op(off);
      end else begin
         case (int'(a))
            0:  w.op = U_SAR_PC;
            1:  w.op = U_READ;
            2:  w.op = U_IR_SDR;
            3:  w.op = U_SDR_OPND;
            4:  w.op = U_DISPATCH;
            16, 26, 36: w.op = U_READ;
            17, 27: w.op = U_TMP_SDR;
            18: w.op = U_ADD;
            28: w.op = U_SUB;
            37: w.op = U_ACC_SDR;
            46: w.op = U_SDR_ACC;
            47: w.op = U_WRITE;
            50, 62: w.op = U_PC_SDR;
            60: w.op = U_SKIP;
            61: w = '{op: U_JUMP, tgt: UPC_W'(64)};
            64: w.op = U_TMP_ACC;
            65, 70: w.op = U_ACC_PCINC;
            66, 71: w.op = U_PC_ACC;
            67: w.op = U_ACC_TMP;
            72: w.op = U_ACC_IMM;
            19, 29, 38, 48, 51, 63, 68, 73: w = '{op: U_JUMP, tgt: '0};
            HALT_ENTRY: w.op = U_HALT;
            ILL_ENTRY:  w.op = U_ILLEGAL;
            default: w.op = U_NOP;
         endcase
      end
      urom = w;
   endfunction

endpackage

// File: rtl/cpu_uc_seq.sv
module cpu_uc_seq
   import cpu_uc_pkg::*;
#(
   parameter int OPC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opc,
   input  logic             acc_zero,
   output uop_e             uop,
   output logic [UPC_W-1:0] upc,
   output logic             halted,
   output logic             error
);

   uword_t           mir;
   logic [UPC_W-1:0] upc_nxt;

   if (2**UPC_W <= ILL_ENTRY) begin : g_bad_upc
      $error("micro-address width too small for control store");
   end

   always_comb begin
      upc_nxt = upc + UPC_W'(1);
      case (mir.op)
         U_DISPATCH: begin
            if (opc != '0 && opc <= OPC_W'(NUM_OPC))
               upc_nxt = UPC_W'(int'(opc) * ENT_STRIDE);
            else
               upc_nxt = UPC_W'(ILL_ENTRY);
         end
         U_JUMP:    upc_nxt = mir.tgt;
         U_SKIP:    upc_nxt = acc_zero ? upc + UPC_W'(2) : upc + UPC_W'(1);
         U_HALT,
         U_ILLEGAL: upc_nxt = upc;
         default:   ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upc    <= '0;
         mir    <= urom('0);
         halted <= 1'b0;
         error  <= 1'b0;
      end else if (!halted) begin
         upc <= upc_nxt;
         mir <= urom(upc_nxt);
         if (mir.op == U_HALT) halted <= 1'b1;
         if (mir.op == U_ILLEGAL) begin
            halted <= 1'b1;
            error  <= 1'b1;
         end
      end
   end

   assign uop = halted ? U_NOP : mir.op;

endmodule

// File: rtl/cpu_uc_dpath.sv
module cpu_uc_dpath
   import cpu_uc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIELD_W    = 16,
   parameter int ADDR_W     = 9,
   parameter bit IMM_SIGNED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  uop_e               uop,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_we,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic [FIELD_W-1:0] opc,
   output logic               acc_zero,
   output logic [DATA_W-1:0]  acc,
   output logic [FIELD_W-1:0] pc,
   output logic [DATA_W-1:0]  ir
);

   localparam int HI_W = DATA_W - FIELD_W;

   logic [DATA_W-1:0] sdr, tmp, sdr_eff, imm_ext;
   logic [ADDR_W-1:0] sar;
   logic              rd_pend;

   if (DATA_W != 2 * FIELD_W) begin : g_bad_split
      $error("data word must hold exactly two fields");
   end
   if (ADDR_W > FIELD_W) begin : g_bad_addr
      $error("address wider than operand field");
   end

   // read data arrives one step after READ; consumers in that step see it directly
   assign sdr_eff = rd_pend ? mem_rdata : sdr;

   if (IMM_SIGNED) begin : g_imm_sx
      assign imm_ext = {{HI_W{sdr_eff[FIELD_W-1]}}, sdr_eff[FIELD_W-1:0]};
   end else begin : g_imm_zx
      assign imm_ext = {{HI_W{1'b0}}, sdr_eff[FIELD_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         pc      <= '0;
         ir      <= '0;
         sdr     <= '0;
         tmp     <= '0;
         sar     <= '0;
         rd_pend <= 1'b0;
      end else begin
         rd_pend <= (uop == U_READ);
         if (uop == U_SDR_OPND)     sdr <= {{HI_W{1'b0}}, ir[FIELD_W-1:0]};
         else if (uop == U_SDR_ACC) sdr <= acc;
         else if (rd_pend)          sdr <= mem_rdata;
         case (uop)
            U_SAR_PC:    sar <= pc[ADDR_W-1:0];
            U_SAR_TMP:   sar <= tmp[ADDR_W-1:0];
            U_IR_SDR:    ir  <= sdr_eff;
            U_TMP_ACC:   tmp <= acc;
            U_TMP_SDR:   tmp <= sdr_eff;
            U_ACC_TMP:   acc <= tmp;
            U_ACC_PCINC: acc <= {{HI_W{1'b0}}, pc} + DATA_W'(1);
            U_PC_ACC:    pc  <= acc[FIELD_W-1:0];
            U_PC_SDR:    pc  <= sdr_eff[FIELD_W-1:0];
            U_ADD:       acc <= acc + tmp;
            U_SUB:       acc <= acc - tmp;
            U_ACC_SDR:   acc <= sdr_eff;
            U_ACC_IMM:   acc <= imm_ext;
            default:     ;
         endcase
      end
   end

   assign mem_addr  = sar;
   assign mem_we    = (uop == U_WRITE);
   assign mem_wdata = sdr;
   assign opc       = ir[DATA_W-1:FIELD_W];
   assign acc_zero  = (acc == '0);

endmodule

// File: rtl/cpu_uc_core.sv
module cpu_uc_core
   import cpu_uc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIELD_W    = 16,
   parameter int ADDR_W     = 9,
   parameter bit IMM_SIGNED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_we,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               halted,
   output logic               error,
   output logic [DATA_W-1:0]  dbg_acc,
   output logic [FIELD_W-1:0] dbg_pc,
   output logic [DATA_W-1:0]  dbg_ir,
   output logic [UPC_W-1:0]   dbg_upc
);

   uop_e               uop;
   logic [FIELD_W-1:0] opc;
   logic               acc_zero;

   cpu_uc_seq #(.OPC_W(FIELD_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .opc      (opc),
      .acc_zero (acc_zero),
      .uop      (uop),
      .upc      (dbg_upc),
      .halted   (halted),
      .error    (error)
   );

   cpu_uc_dpath #(
      .DATA_W     (DATA_W),
      .FIELD_W    (FIELD_W),
      .ADDR_W     (ADDR_W),
      .IMM_SIGNED (IMM_SIGNED)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .uop       (uop),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .opc       (opc),
      .acc_zero  (acc_zero),
      .acc       (dbg_acc),
      .pc        (dbg_pc),
      .ir        (dbg_ir)
   );

endmodule

// File: rtl/cpu_uc_chk.sv
module cpu_uc_chk
   import cpu_uc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int FIELD_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mem_we,
   input logic               halted,
   input logic               error,
   input logic [DATA_W-1:0]  dbg_acc,
   input logic [FIELD_W-1:0] dbg_pc,
   input logic [UPC_W-1:0]   dbg_upc
);

   p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_upc == UPC_W'(0) && !halted) |=> dbg_upc == UPC_W'(1));

   p_fetch_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_upc <= UPC_W'(4)) |-> !mem_we);

   p_pc_via_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_upc == UPC_W'(71) && !halted) |=> dbg_pc == $past(dbg_acc[FIELD_W-1:0]));

   p_skip_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_upc == UPC_W'(60) && dbg_acc == '0 && !halted) |=> dbg_upc == UPC_W'(62));

   p_skip_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_upc == UPC_W'(60) && dbg_acc != '0 && !halted) |=> dbg_upc == UPC_W'(61));

   p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> ($stable(dbg_pc) && $stable(dbg_acc)));

   p_halt_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   p_error_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> halted);

endmodule

bind cpu_uc_core cpu_uc_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mem_we  (mem_we),
   .halted  (halted),
   .error   (error),
   .dbg_acc (dbg_acc),
   .dbg_pc  (dbg_pc),
   .dbg_upc (dbg_upc)
);

// File: tb/cpu_uc_core_test.sv
`timescale 1ns/1ps
module cpu_uc_core_test;

   localparam logic [15:0] OP_ADD = 16'd1, OP_SUB = 16'd2, OP_LDA = 16'd3, OP_STR = 16'd4,
                           OP_BRH = 16'd5, OP_CBR = 16'd6, OP_LDI = 16'd7, OP_HLT = 16'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  mem_addr;
   logic        mem_we;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        halted, error;
   logic [31:0] dbg_acc, dbg_ir;
   logic [15:0] dbg_pc;
   logic [6:0]  dbg_upc;

   logic [31:0] mem [512];
   int n_chk = 0;
   int n_bad = 0;
   int halt_wr = 0;

   always #2 clk = ~clk;

   cpu_uc_core uut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted), .error(error),
      .dbg_acc(dbg_acc), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_upc(dbg_upc)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
      if (rst_n && halted && mem_we) halt_wr <= halt_wr + 1;
   end

   function automatic logic [31:0] ins(input logic [15:0] op, input logic [15:0] opnd);
      return {op, opnd};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_and_reset();
      rst_n = 1'b0;
      for (int i = 0; i < 512; i++) mem[i] = 32'h0;
      halt_wr = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic release_and_run(input string req);
      rst_n = 1'b1;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (halted) break;
      end
      chk({req, " reaches halt"}, {31'b0, halted}, 32'h1);
   endtask

   task automatic t_reset();
      clear_and_reset();
      chk("R1 pc", {16'b0, dbg_pc}, 32'h0);
      chk("R1 acc", dbg_acc, 32'h0);
      chk("R1 halted/error/we", {29'b0, halted, error, mem_we}, 32'h0);
      chk("R1 upc", {25'b0, dbg_upc}, 32'h0);
   endtask

   task automatic t_fetch();
      int exp_seq [10] = '{0, 1, 2, 3, 4, 70, 71, 72, 73, 0};
      clear_and_reset();
      mem[0] = ins(OP_LDI, 16'd5);
      mem[1] = ins(OP_HLT, 16'd0);
      rst_n = 1'b1;
      for (int k = 0; k < 10; k++) begin
         chk($sformatf("R2 upc step %0d", k), {25'b0, dbg_upc}, 32'(exp_seq[k]));
         @(negedge clk);
      end
      release_and_run("R2");
      chk("R2 acc after short program", dbg_acc, 32'd5);
      chk("R2 ir holds halt word", dbg_ir, ins(OP_HLT, 16'd0));
   endtask

   task automatic t_ldi();
      clear_and_reset();
      mem[0] = ins(OP_LDI, 16'hFFFD);
      mem[1] = ins(OP_HLT, 16'd0);
      release_and_run("R3");
      chk("R3 sign-extended immediate", dbg_acc, 32'hFFFF_FFFD);
      chk("R3 pc advanced by one", {16'b0, dbg_pc}, 32'd1);
   endtask

   task automatic t_arith();
      clear_and_reset();
      mem[20] = 32'h7FFF_FFFF;
      mem[21] = 32'h1;
      mem[0] = ins(OP_LDA, 16'd20);
      mem[1] = ins(OP_ADD, 16'd21);
      mem[2] = ins(OP_STR, 16'd22);
      mem[3] = ins(OP_LDI, 16'd0);
      mem[4] = ins(OP_SUB, 16'd21);
      mem[5] = ins(OP_STR, 16'd23);
      mem[6] = ins(OP_HLT, 16'd0);
      release_and_run("R4");
      chk("R4 add wraps", mem[22], 32'h8000_0000);
      chk("R4 sub wraps", mem[23], 32'hFFFF_FFFF);
      chk("R4 final acc", dbg_acc, 32'hFFFF_FFFF);
   endtask

   task automatic t_ldst();
      clear_and_reset();
      mem[30] = 32'h1234_5678;
      mem[0] = ins(OP_LDA, 16'h021E);
      mem[1] = ins(OP_STR, 16'd31);
      mem[2] = ins(OP_HLT, 16'd0);
      release_and_run("R5");
      chk("R5 load ignores high operand bits", dbg_acc, 32'h1234_5678);
      chk("R5 store writes acc", mem[31], 32'h1234_5678);
      chk("R5 pc", {16'b0, dbg_pc}, 32'd2);
   endtask

   task automatic t_brh();
      clear_and_reset();
      mem[0] = ins(OP_BRH, 16'd3);
      mem[1] = ins(OP_LDI, 16'd1);
      mem[2] = ins(OP_HLT, 16'd0);
      mem[3] = ins(OP_LDI, 16'd9);
      mem[4] = ins(OP_HLT, 16'd0);
      release_and_run("R6");
      chk("R6 branch target reached", dbg_acc, 32'd9);
      chk("R6 pc", {16'b0, dbg_pc}, 32'd4);
   endtask

   task automatic t_cbr();
      clear_and_reset();
      mem[0] = ins(OP_LDI, 16'd0);
      mem[1] = ins(OP_CBR, 16'd4);
      mem[2] = ins(OP_LDI, 16'd1);
      mem[3] = ins(OP_HLT, 16'd0);
      mem[4] = ins(OP_LDI, 16'd7);
      mem[5] = ins(OP_HLT, 16'd0);
      release_and_run("R7 taken");
      chk("R7 taken acc", dbg_acc, 32'd7);
      chk("R7 taken pc", {16'b0, dbg_pc}, 32'd5);
      clear_and_reset();
      mem[0] = ins(OP_LDI, 16'd2);
      mem[1] = ins(OP_CBR, 16'd4);
      mem[2] = ins(OP_STR, 16'd10);
      mem[3] = ins(OP_HLT, 16'd0);
      mem[4] = ins(OP_LDI, 16'd7);
      mem[5] = ins(OP_HLT, 16'd0);
      release_and_run("R7 not taken");
      chk("R7 not taken acc kept", dbg_acc, 32'd2);
      chk("R7 not taken fall-through store", mem[10], 32'd2);
      chk("R7 not taken pc", {16'b0, dbg_pc}, 32'd3);
   endtask

   task automatic t_halt();
      logic [15:0] pc0;
      logic [31:0] acc0;
      clear_and_reset();
      mem[0] = ins(OP_LDI, 16'd6);
      mem[1] = ins(OP_STR, 16'd40);
      mem[2] = ins(OP_HLT, 16'd0);
      release_and_run("R8");
      pc0  = dbg_pc;
      acc0 = dbg_acc;
      repeat (20) @(negedge clk);
      chk("R8 halted stays set", {31'b0, halted}, 32'h1);
      chk("R8 pc frozen", {16'b0, dbg_pc}, {16'b0, pc0});
      chk("R8 acc frozen", dbg_acc, acc0);
      chk("R8 no write while halted", 32'(halt_wr), 32'd0);
      chk("R8 no error on halt", {31'b0, error}, 32'h0);
      chk("R8 prior store done", mem[40], 32'd6);
   endtask

   task automatic t_illegal();
      clear_and_reset();
      mem[0] = ins(OP_LDI, 16'd4);
      mem[1] = ins(16'd9, 16'd0);
      release_and_run("R9 opcode 9");
      chk("R9 error on opcode 9", {31'b0, error}, 32'h1);
      chk("R9 acc unchanged", dbg_acc, 32'd4);
      clear_and_reset();
      mem[0] = ins(OP_LDI, 16'd3);
      mem[1] = 32'h0;
      release_and_run("R9 opcode 0");
      chk("R9 error on opcode 0", {31'b0, error}, 32'h1);
   endtask

   initial begin
      #(4 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_fetch();
      t_ldi();
      t_arith();
      t_ldst();
      t_brh();
      t_cbr();
      t_halt();
      t_illegal();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule